// File: doc/BRIEF.md
# Shadow Stack Switch Token Unit

This unit performs the two-command handoff between shadow stacks. A restore command names the slot of a restore token on the stack being entered. The unit validates that token, moves the shadow stack pointer onto it, and overwrites the slot with a token that records the pointer being left. A later save-previous command, which has no operand, pops that token off the new stack. It then places a fresh restore token on the old stack, so that the old stack can be re-entered later by another restore.

Tokens are 64-bit words held in an internal memory of `DEPTH` 8-byte slots. A slot is selected by address bits `[3 +: log2(DEPTH)]`, and higher address bits do not take part in the selection. Two more commands give the surrounding logic access to the memory: one stores a word and one reads a word back. A further command loads the pointer directly. Every command runs as one uninterruptible read-check-update sequence. `busy` stays high for the whole sequence, and a command offered while `busy` is high is dropped. Any failed token check is reported as a control-protection fault with an error code.

Top module: `ssp_switch_unit`

## Requirements
- R1: After reset, `ssp` equals `RESET_PTR` (default 0), and `busy`, `done` and `fault` are all 0.
- R2: The command encoding on `cmd_type` is 0 restore, 1 save-previous, 2 store, 3 load and 4 set pointer. A store (2) writes `cmd_data` into the slot at `cmd_addr`. A load (3) returns that slot's word on `rd_data` in the `done` cycle.
- R3: A restore (0) succeeds only when all of the following hold: `cmd_addr[2:0]` is 0; the token at `cmd_addr` has bit 1 equal to 0 and bit 0 equal to `mode64`; and the token with its low two bits cleared equals `cmd_addr + 8`. On success, `ssp` becomes `cmd_addr`, and the slot is rewritten with the old `ssp` with bits [1:0] replaced by {1, `mode64`}.
- R4: A restore that fails its check raises `fault` with `fault_code` 4 and leaves `ssp` and the memory unchanged.
- R5: A save-previous (1) reads the token at `ssp`. When the token's bit 1 is 1, `ssp` advances by 8. Let P be the token with bits [1:0] cleared. A restore token is then written to slot P−8, holding P in bits [63:2], 0 in bit 1 and the popped token's bit 0 in bit 0.
- R6: A save-previous whose token at `ssp` has bit 1 equal to 0 raises `fault` with `fault_code` 4 and changes neither `ssp` nor the memory.
- R7: A command accepted with `ext_fail` high performs no action and completes with `fault` high and `fault_code` 5.
- R8: A command accepted on a rising edge produces a one-cycle `done` pulse two edges later. `busy` is high for exactly the two cycles in between, and a command offered while `busy` is high is ignored.
- R9: A set-pointer command (4) loads `ssp` with `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_type | input | 3 | Command encoding (see R2) |
| cmd_addr | input | 64 | Operand address |
| cmd_data | input | 64 | Word for the store command |
| mode64 | input | 1 | Current mode, 1 for 64-bit |
| ext_fail | input | 1 | Busy-token check failure reported from outside |
| busy | output | 1 | Sequence in progress; commands are dropped |
| ssp | output | 64 | Shadow stack pointer |
| rd_data | output | 64 | Word returned by a load |
| done | output | 1 | Command complete pulse |
| fault | output | 1 | Control-protection fault, valid with done |
| fault_code | output | 3 | 4 token check, 5 external busy-token failure |

## Verification
On every cycle, the assertions check the following: the pointer is held across any fault; a successful restore leaves an 8-byte-aligned pointer equal to its operand; a successful save-previous advances the pointer by exactly 8; an externally failed command always carries code 5; and busy and done follow their fixed shape. Only the bench's scenarios can show what ends up in memory. That covers the rewritten previous-pointer token, the restore token placed below the old pointer, and a dropped command leaving a slot untouched. It also covers the exact combination of alignment, mode and address tests that decides whether a restore passes. The bench shows all of these by reading slots back through the load command and comparing them against its own model.

// File: rtl/ssp_switch_unit.sv
module ssp_switch_unit #(
  parameter int          DEPTH     = 1024,
  parameter logic [63:0] RESET_PTR = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_type,
  input  logic [63:0] cmd_addr,
  input  logic [63:0] cmd_data,
  input  logic        mode64,
  input  logic        ext_fail,
  output logic        busy,
  output logic [63:0] ssp,
  output logic [63:0] rd_data,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_code
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [2:0] C_RSTOR = 3'd0, C_SAVE = 3'd1, C_WR = 3'd2, C_RD = 3'd3, C_SETP = 3'd4;
  localparam logic [2:0] E_TOKEN = 3'd4, E_EXT = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} st_t;
  st_t st;

  logic [63:0] mem [DEPTH];
  logic [2:0]  c_type;
  logic [63:0] c_addr, c_data, tok;
  logic        c_mode, c_ext;

  wire is_rstor = c_type == C_RSTOR;
  wire is_save  = c_type == C_SAVE;
  wire is_wr    = c_type == C_WR;
  wire is_rd    = c_type == C_RD;
  wire is_setp  = c_type == C_SETP;

  wire [63:0] fetch_addr = is_save ? ssp : c_addr;
  wire [63:0] tok_ptr    = {tok[63:2], 2'b00};
  wire rstor_ok = (c_addr[2:0] == 3'b000) && !tok[1] && (tok[0] == c_mode)
                  && (tok_ptr == c_addr + 64'd8);
  wire fail  = c_ext | (is_rstor & ~rstor_ok) | (is_save & ~tok[1]);
  wire wr_en = (st == S_EXEC) && !fail && (is_rstor | is_save | is_wr);

  logic [63:0] wr_addr, wr_data;
  always_comb begin
    wr_addr = c_addr;
    wr_data = c_data;
    if (is_rstor) wr_data = {ssp[63:2], 1'b1, c_mode};
    else if (is_save) begin
      wr_addr = tok_ptr - 64'd8;
      wr_data = {tok_ptr[63:2], 1'b0, tok[0]};
    end
  end

  assign busy = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ssp        <= RESET_PTR;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= 3'd0;
      rd_data    <= 64'd0;
      c_type     <= C_SETP;
      c_addr     <= 64'd0;
      c_data     <= 64'd0;
      c_mode     <= 1'b0;
      c_ext      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          c_type <= cmd_type;
          c_addr <= cmd_addr;
          c_data <= cmd_data;
          c_mode <= mode64;
          c_ext  <= ext_fail;
          st     <= S_FETCH;
        end
        S_FETCH: st <= S_EXEC;
        default: begin
          st         <= S_IDLE;
          done       <= 1'b1;
          fault      <= fail;
          fault_code <= fail ? (c_ext ? E_EXT : E_TOKEN) : 3'd0;
          if (!fail) begin
            if (is_rstor || is_setp) ssp <= c_addr;
            else if (is_save)        ssp <= ssp + 64'd8;
            if (is_rd)               rd_data <= tok;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FETCH) tok <= mem[fetch_addr[3 +: IW]];
    if (wr_en) mem[wr_addr[3 +: IW]] <= wr_data;
  end

  p_hold_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ssp == $past(ssp));
  p_restore_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && is_rstor) |-> (ssp[2:0] == 3'b000 && ssp == c_addr));
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && is_save) |-> ssp == $past(ssp) + 64'd8);
  p_ext_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_ext) |-> (fault && fault_code == E_EXT));
  p_fault_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && (fault_code == E_TOKEN || fault_code == E_EXT)));
  p_busy_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/ssp_switch_unit_bench.sv
`timescale 1ns/1ps
module ssp_switch_unit_bench;
  localparam int DEPTH = 1024;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, mode64 = 0, ext_fail = 0;
  logic [2:0] cmd_type = 0;
  logic [63:0] cmd_addr = 0, cmd_data = 0;
  logic busy, done, fault;
  logic [63:0] ssp, rd_data;
  logic [2:0] fault_code;

  ssp_switch_unit #(.DEPTH(DEPTH)) u_ssp_switch_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .mode64(mode64), .ext_fail(ext_fail),
    .busy(busy), .ssp(ssp), .rd_data(rd_data), .done(done), .fault(fault),
    .fault_code(fault_code));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] mm [DEPTH];
  logic [63:0] m_ssp = 0;

  function automatic int slot(input logic [63:0] a);
    return int'((a >> 3) % DEPTH);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run(input logic [2:0] t, input logic [63:0] a, input logic [63:0] d,
                     input logic m, input logic e, input string req);
    logic [63:0] tk, p;
    bit ef, okc;
    logic [2:0] ec;
    logic [63:0] es, er;
    int lat;
    bit wr;
    logic [63:0] wa, wd;
    tk = mm[slot(t == 3'd1 ? m_ssp : a)];
    p = {tk[63:2], 2'b00};
    ef = 0; ec = 0; es = m_ssp; er = 'x; wr = 0; wa = a; wd = d;
    if (e) begin ef = 1; ec = 5; end
    else case (t)
      3'd0: begin
        okc = (a[2:0] == 0) && !tk[1] && (tk[0] == m) && (p == a + 8);
        if (!okc) begin ef = 1; ec = 4; end
        else begin es = a; wr = 1; wd = {m_ssp[63:2], 1'b1, m}; end
      end
      3'd1: begin
        if (!tk[1]) begin ef = 1; ec = 4; end
        else begin es = m_ssp + 8; wr = 1; wa = p - 8; wd = {p[63:2], 1'b0, tk[0]}; end
      end
      3'd2: wr = 1;
      3'd3: er = tk;
      3'd4: es = a;
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_type = t; cmd_addr = a; cmd_data = d; mode64 = m; ext_fail = e;
    @(negedge clk);
    cmd_valid = 0; ext_fail = 0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk(lat == 3, "R8", "done latency", 64'(lat), 64'd3);
    chk(fault == ef, req, "fault", 64'(fault), 64'(ef));
    if (ef) chk(fault_code == ec, ef && e ? "R7" : req, "fault_code", 64'(fault_code), 64'(ec));
    chk(ssp == es, req, "ssp", ssp, es);
    if (t == 3'd3 && !ef) chk(rd_data == er, req, "rd_data", rd_data, er);
    if (wr) mm[slot(wa)] = wd;
    m_ssp = es;
  endtask

  task automatic read_chk(input logic [63:0] a, input string req);
    run(3'd3, a, 0, 0, 0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] a, tk, op;
    logic m;
    int kind;
    void'($urandom(32'd1234));
    #12;
    chk(ssp == 0 && !busy && !done && !fault, "R1", "reset state",
        {ssp[60:0], busy, done, fault}, 64'd0);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) begin
      mm[i] = 0;
      run(3'd2, 64'(i) << 3, 0, 0, 0, "R2");
    end
    // worked example
    run(3'd4, 64'h1000, 0, 1, 0, "R9");
    run(3'd2, 64'h3ff8, 64'h4001, 1, 0, "R2");
    read_chk(64'h3ff8, "R2");
    run(3'd0, 64'h3ff8, 0, 1, 0, "R3");
    chk(ssp == 64'h3ff8, "R3", "example ssp", ssp, 64'h3ff8);
    read_chk(64'h3ff8, "R3");
    chk(rd_data == 64'h1003, "R3", "prev token", rd_data, 64'h1003);
    run(3'd1, 0, 0, 1, 0, "R5");
    chk(ssp == 64'h4000, "R5", "example pop", ssp, 64'h4000);
    read_chk(64'h0ff8, "R5");
    chk(rd_data == 64'h1001, "R5", "restore token", rd_data, 64'h1001);
    // restore failures
    run(3'd4, 64'h0800, 0, 0, 0, "R9");
    run(3'd2, 64'h0200, 64'h0209, 1, 0, "R2");
    run(3'd0, 64'h0204, 0, 1, 0, "R4");
    run(3'd0, 64'h0200, 0, 0, 0, "R4");
    run(3'd2, 64'h0200, 64'h0211, 1, 0, "R2");
    run(3'd0, 64'h0200, 0, 1, 0, "R4");
    run(3'd2, 64'h0200, 64'h020b, 1, 0, "R2");
    run(3'd0, 64'h0200, 0, 1, 0, "R4");
    read_chk(64'h0200, "R4");
    chk(rd_data == 64'h020b, "R4", "slot untouched", rd_data, 64'h020b);
    // save-previous on a non-previous token
    run(3'd2, 64'h0800, 64'h0001, 0, 0, "R2");
    run(3'd1, 0, 0, 0, 0, "R6");
    read_chk(64'h07f8, "R6");
    // external failure
    run(3'd2, 64'h0300, 64'h0308, 0, 0, "R2");
    run(3'd0, 64'h0300, 0, 0, 1, "R7");
    chk(ssp == 64'h0800, "R7", "ssp kept", ssp, 64'h0800);
    // command while busy is dropped
    run(3'd2, 64'h0400, 64'h5555, 0, 0, "R2");
    @(negedge clk);
    cmd_valid = 1; cmd_type = 3'd2; cmd_addr = 64'h0400; cmd_data = 64'h1111;
    @(negedge clk);
    cmd_valid = 0; cmd_type = 3'd2; cmd_addr = 64'h0400; cmd_data = 64'h9999;
    chk(busy == 1, "R8", "busy", 64'(busy), 64'd1);
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    mm[slot(64'h0400)] = 64'h1111;
    read_chk(64'h0400, "R8");
    chk(rd_data == 64'h1111, "R8", "dropped write", rd_data, 64'h1111);
    // random mix
    for (int it = 0; it < 300; it++) begin
      a = 64'($urandom % DEPTH) << 3;
      m = 1'($urandom % 2);
      kind = int'($urandom % 5);
      tk = (a + 8) | 64'(m);
      op = a;
      case (kind)
        1: op = a + 4;
        2: tk[0] = ~m;
        3: tk = tk + 64'h10;
        4: tk[1] = 1'b1;
        default: ;
      endcase
      run(3'd2, a, tk, m, 0, "R2");
      run(3'd0, op, 0, m, ($urandom % 16) == 0, kind == 0 ? "R3" : "R4");
      if ($urandom % 2) begin
        if ($urandom % 3 == 0)
          run(3'd2, m_ssp, {50'($urandom), 12'($urandom), 1'($urandom), m}, m, 0, "R2");
        run(3'd1, 0, 0, m, ($urandom % 16) == 0, "R5");
        read_chk(m_ssp - 8, "R5");
      end
    end
    finish_run();
  end
endmodule